// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block holds an 8-bit up-counter that software loads and reads over a plain write port and a continuously visible count output. The counter advances either on instruction-cycle ticks supplied by the surrounding core or on edges of an external clock pin. The pin is first brought into the internal clock domain through a flop chain, and then either its rising or its falling transitions are taken as count events.

A single 8-bit prescaler sits between the event source and the counter. Software can steer it away to a watchdog path. In that case the counter sees every event directly, and the prescaler divides a separate watchdog tick and presents the divided pulse on a tap output. Loading the counter holds off counting for the next two instruction cycles. When the prescaler serves the counter, the load also restarts the prescaler. A wrap from the top count to zero produces a one-cycle overflow pulse that an interrupt controller can use.

Top module: `tmr_unit`

## Requirements
- R1: During and right after reset, `cnt_q` is 0x00 and `ovf_pulse` and `psc_tap` are low.
- R2: A cycle with `wr_en` high loads `wr_data` into the counter, and the value appears on `cnt_q` after that clock edge.
- R3: With `cfg[5]` = 0 (source = tick), the counter takes one count event per `tick_en` pulse.
- R4: With `cfg[5]` = 1 and `cfg[4]` = 0, a count event is a rising edge of `ext_pin`. Falling edges do nothing.
- R5: With `cfg[5]` = 1 and `cfg[4]` = 1, a count event is a falling edge of `ext_pin`. Rising edges do nothing.
- R6: The first two `tick_en` pulses after a write cycle advance nothing, even if they carry a count. A `tick_en` in the write cycle itself is not one of the two.
- R7: With `cfg[3]` = 0 the prescaler sits in the counter path. The counter advances once per 2^(n+1) count events, where n = `cfg[2:0]` (ratios from 1:2 up to 1:256).
- R8: A pin edge that is first sampled at clock edge k shows on `cnt_q` after edge k+2. `cnt_q` is unchanged after edges k and k+1.
- R9: With `cfg[3]` = 1 the counter bypasses the prescaler and advances on every count event (1:1).
- R10: A count at 0xFF wraps to 0x00. `ovf_pulse` is high for exactly the one cycle in which `cnt_q` first reads 0x00 after the wrap.
- R11: With `cfg[3]` = 1 the prescaler counts `wdt_tick` pulses. `psc_tap` is high during every 2^(n+1)-th `wdt_tick` pulse, at the same time as that pulse. `wdt_tick` never changes `cnt_q`.
- R12: With `cfg[3]` = 0, `psc_tap` stays low and `wdt_tick` has no effect on `cnt_q`.
- R13: With `cfg[3]` = 0, a counter write restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per instruction cycle |
| ext_pin | input | 1 | External clock pin, asynchronous |
| wdt_tick | input | 1 | Watchdog time-base pulse, divided when the prescaler is steered to the watchdog |
| cfg | input | 6 | {source select, falling-edge select, prescaler-to-watchdog, rate[2:0]} |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Value to load into the counter |
| cnt_q | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on wrap to zero |
| psc_tap | output | 1 | Divided watchdog pulse |

## Verification
Every internal fault reaches `cnt_q` within a few count events. A hold counter that is stuck or too short gives an extra count after a write. A stale prescaler phase shifts the first count after a reload by whole events. A wrong synchroniser depth moves the pin-driven increment off its edge-exact cycle. Prescaler phase errors in the watchdog route show up as `psc_tap` pulses that are too many or too few over one full divide window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic {
      SRC_TICK = 1'b0,
      SRC_PIN  = 1'b1
   } tmr_src_e;

   typedef enum logic {
      ROUTE_COUNTER  = 1'b0,
      ROUTE_WATCHDOG = 1'b1
   } psc_route_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_ev
);
   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= 1'b0;
         else if (i == 0) stage_q[i] <= pin;
         else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else prev_q <= stage_q[STAGES-1];
   end

   always_comb begin
      if (fall_sel) edge_ev = prev_q & ~stage_q[STAGES-1];
      else          edge_ev = stage_q[STAGES-1] & ~prev_q;
   end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W  = 8,
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [RATE_W-1:0] rate,
   output logic              fire
);
   logic [PSC_W-1:0] div_q;
   logic [PSC_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < PSC_W; i++) mask[i] = (i <= int'(rate));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (clr)  div_q <= '0;
      else if (step) div_q <= div_q + 1'b1;
   end

   assign fire = step & ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W      = 8,
   parameter int HOLD_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             inc,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q
);
   logic held;

   if (HOLD_TICKS > 0) begin : g_hold
      localparam int HW = $clog2(HOLD_TICKS + 1);
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        hold_q <= '0;
         else if (wr_en)                    hold_q <= HW'(HOLD_TICKS);
         else if (tick_en && hold_q != '0)  hold_q <= hold_q - 1'b1;
      end
      assign held = (hold_q != '0);
   end else begin : g_nohold
      assign held = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (wr_en) begin
         cnt_q <= wr_data;
         ovf_q <= 1'b0;
      end else if (inc && !held) begin
         cnt_q <= cnt_q + 1'b1;
         ovf_q <= (cnt_q == '1);
      end else begin
         ovf_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PSC_W       = 8,
   parameter int RATE_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_TICKS  = 2,
   localparam int CFG_W      = RATE_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             ext_pin,
   input  logic             wdt_tick,
   input  logic [CFG_W-1:0] cfg,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_pulse,
   output logic             psc_tap
);
   localparam int IDX_ROUTE = RATE_W;
   localparam int IDX_EDGE  = RATE_W + 1;
   localparam int IDX_SRC   = RATE_W + 2;

   if (PSC_W < (1 << RATE_W)) begin : g_bad_psc
      $error("PSC_W too narrow for the largest rate code");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   tmr_src_e   src_sel;
   psc_route_e route;
   logic       pin_ev, src_ev, psc_step, psc_clr, psc_fire, cnt_inc;

   assign src_sel = tmr_src_e'(cfg[IDX_SRC]);
   assign route   = psc_route_e'(cfg[IDX_ROUTE]);

   tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin),
      .fall_sel(cfg[IDX_EDGE]), .edge_ev(pin_ev)
   );

   assign src_ev   = (src_sel == SRC_PIN) ? pin_ev : tick_en;
   assign psc_step = (route == ROUTE_WATCHDOG) ? wdt_tick : src_ev;
   assign psc_clr  = wr_en && (route == ROUTE_COUNTER);

   tmr_prescaler #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .clr(psc_clr), .step(psc_step),
      .rate(cfg[RATE_W-1:0]), .fire(psc_fire)
   );

   assign cnt_inc = (route == ROUTE_WATCHDOG) ? src_ev : psc_fire;
   assign psc_tap = (route == ROUTE_WATCHDOG) && psc_fire;

   tmr_core #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .inc(cnt_inc), .tick_en(tick_en), .cnt_q(cnt_q), .ovf_q(ovf_pulse)
   );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic             wdt_tick,
   input logic             psa_bit,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ovf_pulse,
   input logic             psc_tap
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt_q == $past(wr_data)); // R2
   AST_HOLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(wr_en) && !wr_en) |=> $stable(cnt_q)); // R6
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(wr_en) && cnt_q != $past(cnt_q)) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3
   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> cnt_q == '0); // R10
   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse); // R10
   AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !psa_bit |-> !psc_tap); // R12
   AST_TAP_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      psc_tap |-> wdt_tick); // R11
endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .wdt_tick(wdt_tick), .psa_bit(cfg[RATE_W]), .cnt_q(cnt_q),
   .ovf_pulse(ovf_pulse), .psc_tap(psc_tap)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       ext_pin = 1'b0;
   logic       wdt_tick = 1'b0;
   logic [5:0] cfg = 6'b001000;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] cnt_q;
   logic       ovf_pulse, psc_tap;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   tmr_unit uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_pin(ext_pin),
      .wdt_tick(wdt_tick), .cfg(cfg), .wr_en(wr_en), .wr_data(wr_data),
      .cnt_q(cnt_q), .ovf_pulse(ovf_pulse), .psc_tap(psc_tap)
   );

   initial forever #2 clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic pin(logic b);
      @(negedge clk); ext_pin = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 cnt", cnt_q, 8'h00);
      chk("R1 ovf", ovf_pulse, 0);
      chk("R1 tap", psc_tap, 0);
   endtask

   task automatic t_write;
      wr(8'hA5);
      chk("R2 load", cnt_q, 8'hA5);
      wr(8'h3C);
      chk("R2 reload", cnt_q, 8'h3C);
   endtask

   task automatic t_timer_bypass;
      cfg = 6'b001000;
      wr(8'h10);
      tick(2);
      chk("R6 held", cnt_q, 8'h10);
      tick(3);
      chk("R3 R9 ticks", cnt_q, 8'h13);
   endtask

   task automatic t_prescale;
      cfg = 6'b000000;
      wr(8'h00);
      tick(10);
      chk("R7 1:2", cnt_q, 8'h04);
      cfg = 6'b000010;
      wr(8'h00);
      tick(16);
      chk("R7 1:8", cnt_q, 8'h02);
      cfg = 6'b000111;
      wr(8'h00);
      tick(255);
      chk("R7 1:256 before", cnt_q, 8'h00);
      tick(1);
      chk("R7 1:256 after", cnt_q, 8'h01);
   endtask

   task automatic t_psc_clear;
      cfg = 6'b000001;
      wr(8'h20);
      tick(3);
      wr(8'h20);
      tick(4);
      chk("R13 restart", cnt_q, 8'h21);
   endtask

   task automatic t_rise;
      cfg = 6'b101000;
      wr(8'h00);
      tick(2);
      chk("R3 tick ignored in pin mode", cnt_q, 8'h00);
      @(negedge clk); ext_pin = 1'b1;
      @(negedge clk); chk("R8 edge k", cnt_q, 8'h00);
      @(negedge clk); chk("R8 edge k+1", cnt_q, 8'h00);
      @(negedge clk); chk("R8 edge k+2", cnt_q, 8'h01);
      pin(1'b0);
      chk("R4 fall ignored", cnt_q, 8'h01);
      pin(1'b1);
      chk("R4 second rise", cnt_q, 8'h02);
      pin(1'b0);
   endtask

   task automatic t_fall;
      cfg = 6'b111000;
      wr(8'h40);
      tick(2);
      pin(1'b1);
      chk("R5 rise ignored", cnt_q, 8'h40);
      pin(1'b0);
      chk("R5 fall counted", cnt_q, 8'h41);
      pin(1'b1);
      pin(1'b0);
      chk("R5 second fall", cnt_q, 8'h42);
   endtask

   task automatic t_wrap;
      cfg = 6'b001000;
      wr(8'hFE);
      tick(3);
      chk("R10 at FF", cnt_q, 8'hFF);
      chk("R10 no early ovf", ovf_pulse, 0);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      chk("R10 wrapped", cnt_q, 8'h00);
      chk("R10 ovf high", ovf_pulse, 1);
      @(negedge clk);
      chk("R10 ovf one cycle", ovf_pulse, 0);
   endtask

   task automatic t_wdt;
      int taps = 0;
      cfg = 6'b001001;
      wr(8'h55);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); wdt_tick = 1'b1;
         #1 if (psc_tap) taps++;
         @(negedge clk); wdt_tick = 1'b0;
      end
      chk("R11 taps per 8 at 1:4", taps, 2);
      chk("R11 cnt untouched", cnt_q, 8'h55);
      taps = 0;
      cfg = 6'b000001;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); wdt_tick = 1'b1;
         #1 if (psc_tap) taps++;
         @(negedge clk); wdt_tick = 1'b0;
      end
      chk("R12 tap silent", taps, 0);
      chk("R12 cnt untouched", cnt_q, 8'h55);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_write();
      t_timer_bypass();
      t_prescale();
      t_psc_clear();
      t_rise();
      t_fall();
      t_wrap();
      t_wdt();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule